// File: doc/BRIEF.md
# Six-Control-Bit Preprocessing ALU

This is a purely combinational arithmetic-logic unit. It works on two two's complement operands, x and y, and produces a result word plus two status flags. Six independent control bits set up a fixed processing chain. First, each operand may be cleared to zero. Then each operand may be bitwise inverted. The two conditioned operands are then either added or ANDed bitwise. Finally, the result may be inverted.

From this chain the caller gets constants, copies of an operand, negations, increments, decrements, sums, differences, AND and OR. There is no opcode table. A datapath drives the six bits straight from its instruction field and reads the result and the two flags in the same evaluation.

The word width is a parameter, with a default of 16. A second parameter chooses the adder variant: an explicit ripple chain or the built-in addition operator. Any carry out of the top bit is dropped, and the unit reports no overflow.

Top module: `alu6`

## Requirements
- R1: When an operand's clear bit is 1, that operand enters the later stages as all zeros, whatever its input value.
- R2: Inversion is applied after clearing. An operand with its invert bit set is passed on bitwise complemented, so clear plus invert gives all ones.
- R3: When `sel_sum` is 1, the pre-inversion result is the sum of the two conditioned operands modulo 2^WIDTH. The carry out of the top bit is discarded.
- R4: When `sel_sum` is 0, the pre-inversion result is the bitwise AND of the two conditioned operands.
- R5: When `inv_out` is 1, `result` is the bitwise complement of the value computed in R3 or R4. Otherwise it is that value unchanged.
- R6: `is_zero` is 1 exactly when every bit of `result` is 0.
- R7: `is_neg` is 1 exactly when the most significant bit of `result` is 1.
- R8: Control codes are written as {clr_x,inv_x,clr_y,inv_y,sel_sum,inv_out}. These codes give the following functions:
  - 101010 gives 0.
  - 111111 gives 1.
  - 111010 gives -1.
  - 001110 gives x-1.
  - 011111 gives x+1.
  - 001111 gives -x.
  - 010011 gives x-y.
  - 000111 gives y-x.
  - 010101 gives x OR y.
  - 000000 gives x AND y.
  - 000010 gives x+y.
- R9: The unit holds no state. `result`, `is_zero` and `is_neg` reflect a change of inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | WIDTH | First operand |
| op_y | input | WIDTH | Second operand |
| clr_x | input | 1 | Clear x to zero |
| inv_x | input | 1 | Invert x after clearing |
| clr_y | input | 1 | Clear y to zero |
| inv_y | input | 1 | Invert y after clearing |
| sel_sum | input | 1 | 1 selects add, 0 selects bitwise AND |
| inv_out | input | 1 | Invert the computed value |
| result | output | WIDTH | Final result word |
| is_zero | output | 1 | Result is all zeros |
| is_neg | output | 1 | Result's top bit is set |

## Verification
The bench drives every one of the 64 control codes against the operand corners 0, 1, -1, 0x7FFF, 0x8000 and an arbitrary pattern, then against random pairs.

Each corner targets a specific mistake:
- If clearing and inversion were swapped, clear plus invert would yield zero instead of all ones, so x-1 and the constants would come out wrong.
- A carry kept or mis-rippled across the top bit shows up on 0x7FFF+1 and on -1+-1.
- A flag taken before the output inversion reports the wrong sign or zero exactly in the codes that set `inv_out`.

A set of named codes is also checked against plain arithmetic on x and y, so that a consistently misordered control vector cannot hide.

// File: rtl/alu6_pkg.sv
package alu6_pkg;

   // Control word, most significant field first: this order is the
   // order in which the stages act on the operands.
   typedef struct packed {
      logic clr_x;
      logic inv_x;
      logic clr_y;
      logic inv_y;
      logic sel_sum;
      logic inv_out;
   } alu6_ctrl_t;

   localparam int NUM_OPERANDS = 2;

endpackage

// File: rtl/alu6_operand_prep.sv
module alu6_operand_prep #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] din,
   input  logic             clr,
   input  logic             inv,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] cleared;

   always_comb begin
      cleared = clr ? '0 : din;
      dout    = inv ? ~cleared : cleared;
   end

   always_comb begin
      if (clr && !inv) begin
         assert_clear_zero_R1: assert (dout == '0)
            else $error("cleared operand not zero");
      end
      if (clr && inv) begin
         assert_clear_then_invert_R2: assert (&dout)
            else $error("clear then invert did not give all ones");
      end
      if (!clr && inv) begin
         assert_invert_only_R2: assert ((dout ^ din) == {WIDTH{1'b1}})
            else $error("inverted operand differs in some bit");
      end
   end

endmodule

// File: rtl/alu6_combine.sv
module alu6_combine #(
   parameter int WIDTH      = 16,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sel_sum,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] sum_w;
   logic [WIDTH-1:0] and_w;

   assign and_w = a & b;

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [WIDTH-1:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_w[i] = a[i] ^ b[i] ^ carry[i];
            if (i < WIDTH - 1) begin : g_carry
               assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
            end
         end
      end else begin : g_operator
         assign sum_w = a + b;
      end
   endgenerate

   assign dout = sel_sum ? sum_w : and_w;

   always_comb begin
      if (sel_sum) begin
         assert_sum_wraps_R3: assert ((dout - a) == b)
            else $error("sum does not wrap modulo 2^WIDTH");
      end else begin
         assert_and_subset_R4: assert (((dout & ~a) == '0) && ((dout & ~b) == '0))
            else $error("AND result has a bit absent from an operand");
      end
   end

endmodule

// File: rtl/alu6_finish.sv
module alu6_finish #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] raw,
   input  logic             inv,
   output logic [WIDTH-1:0] dout,
   output logic             zero,
   output logic             neg
);

   localparam int MSB = WIDTH - 1;

   assign dout = inv ? ~raw : raw;
   assign zero = ~|dout;
   assign neg  = dout[MSB];

   always_comb begin
      assert_out_invert_R5: assert ((dout ^ raw) == {WIDTH{inv}})
         else $error("output inversion wrong");
      assert_zero_flag_R6: assert (zero == (raw == {WIDTH{inv}}))
         else $error("zero flag not taken after inversion");
      assert_neg_flag_R7: assert (neg == (raw[MSB] ^ inv))
         else $error("negative flag not taken after inversion");
   end

endmodule

// File: rtl/alu6.sv
module alu6
   import alu6_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  logic [WIDTH-1:0] op_x,
   input  logic [WIDTH-1:0] op_y,
   input  logic             clr_x,
   input  logic             inv_x,
   input  logic             clr_y,
   input  logic             inv_y,
   input  logic             sel_sum,
   input  logic             inv_out,
   output logic [WIDTH-1:0] result,
   output logic             is_zero,
   output logic             is_neg
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu6: WIDTH must be at least 2");
      end
   endgenerate

   alu6_ctrl_t ctl;
   assign ctl = '{clr_x: clr_x, inv_x: inv_x, clr_y: clr_y, inv_y: inv_y,
                  sel_sum: sel_sum, inv_out: inv_out};

   logic [NUM_OPERANDS-1:0][WIDTH-1:0] ops_in;
   logic [NUM_OPERANDS-1:0][WIDTH-1:0] ops_prep;
   logic [NUM_OPERANDS-1:0]            op_clr;
   logic [NUM_OPERANDS-1:0]            op_inv;
   logic [WIDTH-1:0]                   core_out;

   assign ops_in[0] = op_x;
   assign ops_in[1] = op_y;
   assign op_clr    = {ctl.clr_y, ctl.clr_x};
   assign op_inv    = {ctl.inv_y, ctl.inv_x};

   generate
      for (genvar k = 0; k < NUM_OPERANDS; k++) begin : g_prep
         alu6_operand_prep #(.WIDTH(WIDTH)) i_prep (
            .din  (ops_in[k]),
            .clr  (op_clr[k]),
            .inv  (op_inv[k]),
            .dout (ops_prep[k])
         );
      end
   endgenerate

   alu6_combine #(.WIDTH(WIDTH), .RIPPLE_ADD(RIPPLE_ADD)) i_combine (
      .a       (ops_prep[0]),
      .b       (ops_prep[1]),
      .sel_sum (ctl.sel_sum),
      .dout    (core_out)
   );

   alu6_finish #(.WIDTH(WIDTH)) i_finish (
      .raw  (core_out),
      .inv  (ctl.inv_out),
      .dout (result),
      .zero (is_zero),
      .neg  (is_neg)
   );

endmodule

// File: tb/test_alu6.sv
`timescale 1ns/1ps
module test_alu6;

   localparam int W = 16;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [W-1:0] op_x, op_y, result;
   logic [5:0]   code;
   logic         is_zero, is_neg;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   alu6 #(.WIDTH(W)) i_alu6 (
      .op_x    (op_x),
      .op_y    (op_y),
      .clr_x   (code[5]),
      .inv_x   (code[4]),
      .clr_y   (code[3]),
      .inv_y   (code[2]),
      .sel_sum (code[1]),
      .inv_out (code[0]),
      .result  (result),
      .is_zero (is_zero),
      .is_neg  (is_neg)
   );

   // Model written from the requirements: clear, invert, combine, invert.
   function automatic logic [W-1:0] model(logic [5:0] c, logic [W-1:0] x, logic [W-1:0] y);
      logic [W-1:0] a, b, r;
      a = c[5] ? '0 : x;
      a = c[4] ? ~a : a;
      b = c[3] ? '0 : y;
      b = c[2] ? ~b : b;
      r = c[1] ? W'(a + b) : (a & b);
      r = c[0] ? ~r : r;
      return r;
   endfunction

   task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply(logic [5:0] c, logic [W-1:0] x, logic [W-1:0] y);
      @(posedge clk);
      code = c; op_x = x; op_y = y;
      @(negedge clk);
   endtask

   task automatic full_compare(logic [5:0] c, logic [W-1:0] x, logic [W-1:0] y);
      logic [W-1:0] e;
      apply(c, x, y);
      e = model(c, x, y);
      check($sformatf("R1/R2/%s/R5 code=%b x=%h y=%h", c[1] ? "R3" : "R4", c, x, y), result, e);
      check($sformatf("R6 code=%b x=%h y=%h", c, x, y), W'(is_zero), W'(e == '0));
      check($sformatf("R7 code=%b x=%h y=%h", c, x, y), W'(is_neg), W'(e[W-1]));
   endtask

   task automatic named(logic [W-1:0] x, logic [W-1:0] y);
      apply(6'b101010, x, y); check("R8 zero", result, 16'h0000);
      apply(6'b111111, x, y); check("R8 one", result, 16'h0001);
      apply(6'b111010, x, y); check("R8 minus one", result, 16'hFFFF);
      apply(6'b001110, x, y); check("R8 x-1", result, W'(x - 1));
      apply(6'b011111, x, y); check("R8 x+1", result, W'(x + 1));
      apply(6'b001111, x, y); check("R8 -x", result, W'(-x));
      apply(6'b010011, x, y); check("R8 x-y", result, W'(x - y));
      apply(6'b000111, x, y); check("R8 y-x", result, W'(y - x));
      apply(6'b010101, x, y); check("R8 x|y", result, x | y);
      apply(6'b000000, x, y); check("R8 x&y", result, x & y);
      apply(6'b000010, x, y); check("R8 x+y", result, W'(x + y));
   endtask

   initial begin
      logic [W-1:0] corners [6];
      corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h5A3C};
      code = '0; op_x = '0; op_y = '0;
      void'($urandom(32'd2024));

      // Idle state: all-zero inputs give zero with the zero flag set (R6).
      @(negedge clk);
      check("R6 idle result", result, 16'h0000);
      check("R6 idle zero flag", W'(is_zero), 16'h0001);
      check("R7 idle neg flag", W'(is_neg), 16'h0000);

      // Carry discarded at the top bit (R3).
      apply(6'b000010, 16'h7FFF, 16'h0001); check("R3 7FFF+1", result, 16'h8000);
      check("R7 7FFF+1 sign", W'(is_neg), 16'h0001);
      apply(6'b000010, 16'hFFFF, 16'hFFFF); check("R3 wrap -1+-1", result, 16'hFFFE);
      apply(6'b000010, 16'hFFFF, 16'h0001); check("R3 wrap to zero", result, 16'h0000);
      check("R6 wrap zero flag", W'(is_zero), 16'h0001);

      // Clear-then-invert order (R1, R2): y cleared then inverted gives -1.
      apply(6'b001100, 16'h1234, 16'hBEEF); check("R2 x AND ones", result, 16'h1234);
      apply(6'b100000, 16'hFFFF, 16'hFFFF); check("R1 cleared x AND y", result, 16'h0000);

      // No clock needed (R9): outputs follow inputs within the same evaluation.
      @(posedge clk);
      #2 code = 6'b000010; op_x = 16'h0003; op_y = 16'h0004;
      #1 check("R9 immediate sum", result, 16'h0007);
      op_y = 16'h0010;
      #1 check("R9 immediate follow", result, 16'h0013);

      foreach (corners[i]) foreach (corners[j]) named(corners[i], corners[j]);

      foreach (corners[i]) foreach (corners[j])
         for (int c = 0; c < 64; c++) full_compare(6'(c), corners[i], corners[j]);

      for (int n = 0; n < 200; n++) begin
         logic [W-1:0] rx, ry;
         rx = W'($urandom);
         ry = W'($urandom);
         for (int c = 0; c < 64; c++) full_compare(6'(c), rx, ry);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule